// File: doc/BRIEF.md
# Load-Switch Serial Command Register Bank

This block sits behind the serial shift interface of a protected single-channel load switch. It accepts one 8-bit command per strobe from the host, works out which configuration register the command targets, and updates that register. The held values drive the configuration outputs for the load switch:
- output request and current-sense enable
- low and high overcurrent thresholds
- low-overcurrent blanking selection and its disable
- open-load disable
- direct-pin control
- slew/delay selection
- watchdog period selection
- undervoltage and overvoltage disables

Most commands decode the address from bits 6:4 and ignore bit 7. Two address codes also use bit 7, so each of them reaches two different registers. A status command changes no configuration. It only picks which register image is shown on the readback byte, and that byte forms the first byte of the next serial response. Protection timing, the comparators and the bit shifting are handled by neighbouring blocks.

Top module: `spi_cmd_regbank`

## Requirements
- R1: After reset, every configuration output is 0 except `in_pin_en`, which is 1. The readback selector is 0, so `rb_byte` equals `status_word`. `wd_feed` and `proto_err` are 0.
- R2: A command counts only in a cycle where `cmd_valid` is 1. Bits 6:4 give the address. For addresses 001, 010, 011, 100 and 111, bit 7 has no effect on the decode.
- R3: A write to address 001 with bits 3:2 equal to 00 sets `out_req` from bit 0 and `sense_en` from bit 1. The new values are visible after the clock edge that samples the command.
- R4: A write to address 001 with bit 2 or bit 3 set changes no output and no feed state. `proto_err` is 1 for exactly the cycle after the command.
- R5: An accepted address-001 write whose bit 7 differs from the bit 7 of the last accepted such write makes `wd_feed` 1 for one cycle. The remembered bit is 0 after reset.
- R6: A write to address 010 sets `oc_low_sel` from bits 2:0 and `oc_high_sel` from bit 3.
- R7: A write to address 011 sets `blank_sel` from bits 1:0, `blank_dis` from bit 2 and `openload_dis` from bit 3.
- R8: A write to address 100 sets `in_pin_en` to the inverse of bit 1.
- R9: Address 101 with bit 7 = 0 sets `slew_sel` from bits 2:0. Address 101 with bit 7 = 1 sets `wd_sel` from bits 1:0.
- R10: Address 110 with bit 7 = 1 sets `uv_dis` from bit 1 and `ov_dis` from bit 0. Address 110 with bit 7 = 0 changes nothing.
- R11: Address 000 stores bits 2:0 as the readback selector and changes no configuration. `rb_byte` shows one image per selector value:
  - 0: `status_word`
  - 1: {6'b0, sense_en, out_req}
  - 2: {4'b0, oc_high_sel, oc_low_sel}
  - 3: {4'b0, openload_dis, blank_dis, blank_sel}
  - 4: {6'b0, !in_pin_en, 1'b0}
  - 5: {5'b0, slew_sel}
  - 6: {6'b0, wd_sel}
  - 7: {6'b0, uv_dis, ov_dis}
- R12: Writes to address 111 change no output.
- R13: While `cmd_valid` is 0, no output changes, except that `wd_feed` and `proto_err` return to 0 and `rb_byte` follows `status_word` when the selector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 8 | Received command word |
| cmd_valid | input | 1 | One-cycle strobe marking `cmd_word` as a new command |
| status_word | input | 8 | Live device status for readback selector 0 |
| out_req | output | 1 | Output switch request |
| sense_en | output | 1 | Current-sense pin enable |
| oc_low_sel | output | 3 | Low overcurrent threshold code |
| oc_high_sel | output | 1 | High overcurrent threshold code |
| blank_sel | output | 2 | Low-overcurrent blanking time code |
| blank_dis | output | 1 | Low-overcurrent timeout disable |
| openload_dis | output | 1 | Open-load detection disable |
| in_pin_en | output | 1 | External input pin may drive the output |
| slew_sel | output | 3 | Output slew/delay code |
| wd_sel | output | 2 | Watchdog period code |
| uv_dis | output | 1 | Undervoltage detection disable |
| ov_dis | output | 1 | Overvoltage detection disable |
| wd_feed | output | 1 | One-cycle watchdog feed pulse |
| proto_err | output | 1 | One-cycle rejected-command pulse |
| rb_byte | output | 8 | First byte of the next serial response |

## Verification
The output-control command carries two functions in one word: the output and sense update, and the watchdog feed toggle in bit 7. An illegal bit 2 or 3 must suppress both of them and raise the error pulse in the same cycle. The bench sweeps all 256 command words twice, so that bit 7 arrives both equal to and different from the stored feed bit. For each command, a reference model in the bench predicts, for the cycle after the edge, the configuration vector, the readback byte and both pulses. Each result is then checked for that exact cycle. An idle cycle follows each command and confirms that both pulses are gone.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  typedef enum logic [3:0] {
    TG_NONE   = 4'd0,
    TG_STAT   = 4'd1,
    TG_OUTCTL = 4'd2,
    TG_OCLVL  = 4'd3,
    TG_TIMING = 4'd4,
    TG_DIRIN  = 4'd5,
    TG_SLEW   = 4'd6,
    TG_WDOG   = 4'd7,
    TG_SUPPLY = 4'd8,
    TG_NOP    = 4'd9,
    TG_TEST   = 4'd10
  } target_e;

  localparam int N_TGT = 11;

  typedef struct packed {
    logic       out_req;
    logic       sense_en;
    logic [2:0] oc_low;
    logic       oc_high;
    logic [1:0] blank;
    logic       cd_dis;
    logic       ol_dis;
    logic       din_dis;
    logic [2:0] slew;
    logic [1:0] wd;
    logic       uv_dis;
    logic       ov_dis;
  } cfg_t;

  localparam cfg_t CFG_RST = '0;

  // Map a command word onto the register it targets.
  function automatic target_e classify(input logic [CMD_W-1:0] w);
    logic [ADDR_W-1:0] a;
    a = w[6:4];
    unique case (a)
      3'b000:  return TG_STAT;
      3'b001:  return TG_OUTCTL;
      3'b010:  return TG_OCLVL;
      3'b011:  return TG_TIMING;
      3'b100:  return TG_DIRIN;
      3'b101:  return w[7] ? TG_WDOG   : TG_SLEW;
      3'b110:  return w[7] ? TG_SUPPLY : TG_NOP;
      default: return TG_TEST;
    endcase
  endfunction

  // Build the readback byte for a selector value.
  function automatic logic [CMD_W-1:0] rb_image(input cfg_t c,
                                                input logic [SEL_W-1:0] sel,
                                                input logic [CMD_W-1:0] stat);
    unique case (sel)
      3'd0:    return stat;
      3'd1:    return {6'b0, c.sense_en, c.out_req};
      3'd2:    return {4'b0, c.oc_high, c.oc_low};
      3'd3:    return {4'b0, c.ol_dis, c.cd_dis, c.blank};
      3'd4:    return {6'b0, c.din_dis, 1'b0};
      3'd5:    return {5'b0, c.slew};
      3'd6:    return {6'b0, c.wd};
      default: return {6'b0, c.uv_dis, c.ov_dis};
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_valid,
  output logic [N_TGT-1:0] tgt_we,
  output logic             ocr_bad
);
  target_e tgt;

  always_comb tgt = classify(cmd_word);

  for (genvar i = 0; i < N_TGT; i++) begin : g_we
    assign tgt_we[i] = cmd_valid && (tgt == target_e'(4'(i)));
  end

  assign ocr_bad = |cmd_word[3:2];
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TGT-1:0] tgt_we,
  input  logic             ocr_bad,
  input  logic [CMD_W-1:0] data,
  output cfg_t             cfg_q,
  output logic [SEL_W-1:0] rb_sel_q,
  output logic             wd_feed,
  output logic             proto_err
);
  logic feed_bit_q;
  logic ocr_accept;
  logic feed_toggle;

  assign ocr_accept  = tgt_we[TG_OUTCTL] && !ocr_bad;
  assign feed_toggle = ocr_accept && (data[7] != feed_bit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_RST;
      rb_sel_q   <= '0;
      feed_bit_q <= 1'b0;
      wd_feed    <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      wd_feed   <= feed_toggle;
      proto_err <= tgt_we[TG_OUTCTL] && ocr_bad;
      if (tgt_we[TG_STAT]) rb_sel_q <= data[2:0];
      if (ocr_accept) begin
        cfg_q.out_req  <= data[0];
        cfg_q.sense_en <= data[1];
        feed_bit_q     <= data[7];
      end
      if (tgt_we[TG_OCLVL]) begin
        cfg_q.oc_low  <= data[2:0];
        cfg_q.oc_high <= data[3];
      end
      if (tgt_we[TG_TIMING]) begin
        cfg_q.blank  <= data[1:0];
        cfg_q.cd_dis <= data[2];
        cfg_q.ol_dis <= data[3];
      end
      if (tgt_we[TG_DIRIN])  cfg_q.din_dis <= data[1];
      if (tgt_we[TG_SLEW])   cfg_q.slew    <= data[2:0];
      if (tgt_we[TG_WDOG])   cfg_q.wd      <= data[1:0];
      if (tgt_we[TG_SUPPLY]) begin
        cfg_q.uv_dis <= data[1];
        cfg_q.ov_dis <= data[0];
      end
    end
  end

  // R4: a rejected output-control write leaves output and sense untouched
  a_r4_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (cfg_q.out_req == $past(cfg_q.out_req)) &&
                  (cfg_q.sense_en == $past(cfg_q.sense_en)));

  // R5: a feed pulse always follows an accepted output-control write
  a_r5_feed_source: assert property (@(posedge clk) disable iff (!rst_n)
    wd_feed |-> $past(tgt_we[TG_OUTCTL] && !ocr_bad));

  // R13: with no write enable raised, configuration and selector hold
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_we == '0) |=> $stable(cfg_q) && $stable(rb_sel_q));

  // R11: a status command leaves configuration unchanged
  a_r11_stat_no_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we[TG_STAT] |=> $stable(cfg_q));

  // R12: test-address writes leave configuration unchanged
  a_r12_test_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we[TG_TEST] |=> $stable(cfg_q) && $stable(rb_sel_q));

  // R10: no-action writes leave configuration unchanged
  a_r10_nop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we[TG_NOP] |=> $stable(cfg_q));
endmodule

// File: rtl/spi_cmd_readback.sv
module spi_cmd_readback
  import spi_cmd_pkg::*;
(
  input  cfg_t             cfg_q,
  input  logic [SEL_W-1:0] rb_sel_q,
  input  logic [CMD_W-1:0] status_word,
  output logic [CMD_W-1:0] rb_byte
);
  always_comb rb_byte = rb_image(cfg_q, rb_sel_q, status_word);
endmodule

// File: rtl/spi_cmd_regbank.sv
module spi_cmd_regbank
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cmd_word,
  input  logic       cmd_valid,
  input  logic [7:0] status_word,
  output logic       out_req,
  output logic       sense_en,
  output logic [2:0] oc_low_sel,
  output logic       oc_high_sel,
  output logic [1:0] blank_sel,
  output logic       blank_dis,
  output logic       openload_dis,
  output logic       in_pin_en,
  output logic [2:0] slew_sel,
  output logic [1:0] wd_sel,
  output logic       uv_dis,
  output logic       ov_dis,
  output logic       wd_feed,
  output logic       proto_err,
  output logic [7:0] rb_byte
);
  logic [N_TGT-1:0] tgt_we;
  logic             ocr_bad;
  cfg_t             cfg_q;
  logic [SEL_W-1:0] rb_sel_q;

  spi_cmd_decode u_dec (
    .cmd_word (cmd_word),
    .cmd_valid(cmd_valid),
    .tgt_we   (tgt_we),
    .ocr_bad  (ocr_bad)
  );

  spi_cmd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .tgt_we   (tgt_we),
    .ocr_bad  (ocr_bad),
    .data     (cmd_word),
    .cfg_q    (cfg_q),
    .rb_sel_q (rb_sel_q),
    .wd_feed  (wd_feed),
    .proto_err(proto_err)
  );

  spi_cmd_readback u_rb (
    .cfg_q      (cfg_q),
    .rb_sel_q   (rb_sel_q),
    .status_word(status_word),
    .rb_byte    (rb_byte)
  );

  assign out_req      = cfg_q.out_req;
  assign sense_en     = cfg_q.sense_en;
  assign oc_low_sel   = cfg_q.oc_low;
  assign oc_high_sel  = cfg_q.oc_high;
  assign blank_sel    = cfg_q.blank;
  assign blank_dis    = cfg_q.cd_dis;
  assign openload_dis = cfg_q.ol_dis;
  assign in_pin_en    = !cfg_q.din_dis;
  assign slew_sel     = cfg_q.slew;
  assign wd_sel       = cfg_q.wd;
  assign uv_dis       = cfg_q.uv_dis;
  assign ov_dis       = cfg_q.ov_dis;

  // R2: a command reaches at most one register
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_we));

  // R2: nothing is written without the strobe
  a_r2_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (tgt_we == '0));

  // R4: error and feed pulses never coincide
  a_r4_err_no_feed: assert property (@(posedge clk) disable iff (!rst_n)
    !(proto_err && wd_feed));
endmodule

// File: tb/spi_cmd_regbank_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd_word = 8'h00;
  logic       cmd_valid = 1'b0;
  logic [7:0] status_word = 8'h00;
  logic       out_req, sense_en, oc_high_sel, blank_dis, openload_dis;
  logic       in_pin_en, uv_dis, ov_dis, wd_feed, proto_err;
  logic [2:0] oc_low_sel, slew_sel;
  logic [1:0] blank_sel, wd_sel;
  logic [7:0] rb_byte;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_cmd_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .status_word(status_word), .out_req(out_req), .sense_en(sense_en),
    .oc_low_sel(oc_low_sel), .oc_high_sel(oc_high_sel), .blank_sel(blank_sel),
    .blank_dis(blank_dis), .openload_dis(openload_dis), .in_pin_en(in_pin_en),
    .slew_sel(slew_sel), .wd_sel(wd_sel), .uv_dis(uv_dis), .ov_dis(ov_dis),
    .wd_feed(wd_feed), .proto_err(proto_err), .rb_byte(rb_byte)
  );

  // reference model state
  logic       m_out, m_sense, m_hi, m_cd, m_ol, m_din_off, m_uv, m_ov, m_feed;
  logic [2:0] m_lo, m_slew, m_sel;
  logic [1:0] m_blank, m_wd;
  logic       e_feed, e_err;

  function automatic logic [18:0] dut_vec();
    return {out_req, sense_en, oc_low_sel, oc_high_sel, blank_sel, blank_dis,
            openload_dis, in_pin_en, slew_sel, wd_sel, uv_dis, ov_dis};
  endfunction

  function automatic logic [18:0] model_vec();
    return {m_out, m_sense, m_lo, m_hi, m_blank, m_cd, m_ol, !m_din_off,
            m_slew, m_wd, m_uv, m_ov};
  endfunction

  function automatic logic [7:0] model_rb(input logic [7:0] st);
    logic [7:0] r;
    r = 8'h00;
    if (m_sel == 3'd0) r = st;
    else if (m_sel == 3'd1) begin r[0] = m_out; r[1] = m_sense; end
    else if (m_sel == 3'd2) r = 8'(m_lo) + (m_hi ? 8'd8 : 8'd0);
    else if (m_sel == 3'd3) r = 8'(m_blank) + (m_cd ? 8'd4 : 8'd0) + (m_ol ? 8'd8 : 8'd0);
    else if (m_sel == 3'd4) r = m_din_off ? 8'd2 : 8'd0;
    else if (m_sel == 3'd5) r = 8'(m_slew);
    else if (m_sel == 3'd6) r = 8'(m_wd);
    else begin r[1] = m_uv; r[0] = m_ov; end
    return r;
  endfunction

  function automatic string tag_for(input logic [7:0] c);
    int a;
    a = int'(c[6:4]);
    case (a)
      0: return "R11";
      1: return (c[3:2] != 2'b00) ? "R4" : "R3/R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      6: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_out, m_sense, m_hi, m_cd, m_ol, m_din_off, m_uv, m_ov, m_feed} = '0;
    m_lo = 0; m_slew = 0; m_sel = 0; m_blank = 0; m_wd = 0;
  endtask

  // Reference update, written from the requirements (R2..R12).
  task automatic model_apply(input logic [7:0] c);
    logic [2:0] a;
    a = c[6:4];
    e_feed = 1'b0;
    e_err  = 1'b0;
    if (a == 3'd0) m_sel = c[2:0];
    else if (a == 3'd1) begin
      if (c[2] || c[3]) e_err = 1'b1;
      else begin
        m_out = c[0]; m_sense = c[1];
        e_feed = (c[7] ^ m_feed);
        m_feed = c[7];
      end
    end
    else if (a == 3'd2) begin m_lo = c[2:0]; m_hi = c[3]; end
    else if (a == 3'd3) begin m_blank = c[1:0]; m_cd = c[2]; m_ol = c[3]; end
    else if (a == 3'd4) m_din_off = c[1];
    else if (a == 3'd5) begin if (c[7]) m_wd = c[1:0]; else m_slew = c[2:0]; end
    else if (a == 3'd6) begin if (c[7]) begin m_uv = c[1]; m_ov = c[0]; end end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    status_word = 8'hC3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "cfg", 32'(dut_vec()), 32'(model_vec()));
    check("R1", "rb_byte", 32'(rb_byte), 32'h000000C3);
    check("R1", "in_pin_en", 32'(in_pin_en), 32'd1);
    check("R1", "pulses", 32'({wd_feed, proto_err}), 32'd0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 256; c++) begin
        logic [7:0] cw;
        string tg;
        cw = (pass == 0) ? 8'(c) : 8'(255 - c);
        tg = tag_for(cw);
        status_word = cw ^ 8'h5A;
        cmd_word  = cw;
        cmd_valid = 1'b1;
        model_apply(cw);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = ~cw;
        check(tg, "cfg", 32'(dut_vec()), 32'(model_vec()));
        check("R11", "rb_byte", 32'(rb_byte), 32'(model_rb(status_word)));
        check("R5", "wd_feed", 32'(wd_feed), 32'(e_feed));
        check("R4", "proto_err", 32'(proto_err), 32'(e_err));
        // R13: idle cycle with a different word on the bus
        @(negedge clk);
        check("R13", "idle cfg", 32'(dut_vec()), 32'(model_vec()));
        check("R13", "idle pulses", 32'({wd_feed, proto_err}), 32'd0);
      end
    end

    // R1 again after a second reset mid-run
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    status_word = 8'h3C;
    @(negedge clk);
    check("R1", "cfg after reset", 32'(dut_vec()), 32'(model_vec()));
    check("R1", "rb after reset", 32'(rb_byte), 32'h0000003C);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule